// File: doc/BRIEF.md
# Word-Update Coherent Cache Line Controller

This block manages one cache line in a write-back cache that keeps copies coherent by broadcasting writes rather than invalidating them. A present line is always in one of four valid states: exclusive-clean, shared-clean, shared-modified (the single owner of dirty data) and modified. An absent line is simply not present. On the processor side it serves read and write requests. On the shared atomic bus it issues block reads, single-word update broadcasts and whole-block writebacks, and it samples a wired-OR shared line during its own transactions. It also snoops the transactions of other caches, answering with the shared line, flushing dirty data when it owns the block, and writing snooped update words into its own copy.

Requests are level-held on `cpu_req` until `cpu_done` pulses for one cycle. A bus transaction takes place in the cycle in which both `bus_req` and `bus_gnt` are high. The shared line, the fill data and the grant all belong to that one cycle. Snoop inputs describe another master's transaction in the same cycle, and the snoop responses are returned in that cycle.

State encoding on `line_state`: 0 not present, 1 exclusive-clean, 2 shared-clean, 3 shared-modified, 4 modified. Bus and snoop command encoding: 0 none, 1 block read, 2 word update, 3 writeback. In `bus_blk`, `bus_fill` and `snp_flush_data`, word i lies in bits [i*DW +: DW].

Top module: `upd_line_ctrl`

## Requirements
- R1: After reset, line_state is 0 and bus_req, cpu_done and snp_shared are all low.
- R2: A read miss issues one bus read (command 1) for the requested tag. The line becomes 1 if the shared line is low during the grant and 2 if it is high, and cpu_rdata returns the requested word of the fill.
- R3: A write miss issues a bus read. If the shared line is low, the line becomes 4 holding the fill merged with the written word, with no update. If it is high, an update (command 2) follows and the line ends in 3.
- R4: A write hit in state 1 or 4 completes without any bus request, and the line ends in state 4 holding the new word.
- R5: A write hit in state 2 or 3 broadcasts an update carrying the tag, the word index and the written word only. The line ends in 3 if the shared line is high during that update and in 4 otherwise.
- R6: A snooped update (command 2) whose tag matches a line in state 2 or 3 asserts snp_shared, writes the word into the local copy and leaves the line in state 2.
- R7: A snooped read (command 1) with a matching tag asserts snp_shared. State 4 moves to 3 and state 3 stays at 3, both with snp_flush high and the whole block on snp_flush_data. State 1 moves to 2 and state 2 stays at 2, neither flushing.
- R8: While a write hit waits for its update grant, the local copy keeps its old value: a flush before the grant shows the old word. A snooped update that arrives meanwhile is applied first, and the own word overwrites it at the grant.
- R9: A miss that replaces a line in state 3 or 4 first issues a writeback (command 3) carrying the old tag and the whole block, then the bus read. A line in state 1 or 2 is replaced with no writeback.
- R10: When a snoop hits the line in the same cycle as a processor request is presented, the snoop is applied first and the request is decided on the new state. A write to a line that was 1 and is snooped by a read in that cycle becomes an update, not a silent write.
- R11: Snooped writebacks, and snoops whose tag does not match, leave snp_shared and snp_flush low and change neither the state nor the data.
- R12: After any completed update, own or snooped, a read hit of that word returns the value carried by that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_tag | input | TAGW | Block tag of the request |
| cpu_word | input | log2(WORDS) | Word index within the block |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| line_state | output | 3 | Coherence state of the line |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | Command of the requested transaction |
| bus_tag | output | TAGW | Tag of the requested transaction |
| bus_word | output | log2(WORDS) | Word index of an update |
| bus_wdata | output | DW | Word carried by an update |
| bus_blk | output | WORDS*DW | Block carried by a writeback |
| bus_gnt | input | 1 | Grant; the transaction occurs in this cycle |
| bus_shared | input | 1 | Wired-OR shared line during own transaction |
| bus_fill | input | WORDS*DW | Block returned for a bus read |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Its command |
| snp_tag | input | TAGW | Its tag |
| snp_word | input | log2(WORDS) | Its word index (updates) |
| snp_data | input | DW | Its word (updates) |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | This cache supplies the block |
| snp_flush_data | output | WORDS*DW | Block supplied on flush |

## Verification
Two collisions are provoked directly. In the first, a processor write to an exclusive-clean line and a snooped read of the same block are presented in one cycle. The check passes only if the snoop wins, the line turns shared-clean and the write then appears on the bus as an update instead of completing silently. In the second, a write hit is left waiting without a grant while a snooped read and then a snooped update hit the same block. The flushed block must still show the old word, the snooped word must land first, and after the grant the read-back must show the processor's own word with the line in shared-modified.

// File: rtl/upd_pkg.sv
`timescale 1ns/1ps
package upd_pkg;
  typedef enum logic [2:0] {
    LS_NP  = 3'd0,
    LS_EXC = 3'd1,
    LS_SHC = 3'd2,
    LS_SHM = 3'd3,
    LS_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_WB   = 2'd1,
    CT_FILL = 2'd2,
    CT_UPD  = 2'd3
  } ctl_e;
endpackage

// File: rtl/upd_line_store.sv
`timescale 1ns/1ps
module upd_line_store #(
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     fill_en,
  input  logic [WORDS*DW-1:0]      fill_data,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic [WORDS*DW-1:0]      blk_data
);
  logic [DW-1:0] mem [WORDS];

  // a word write in the same cycle as a fill lands on top of the fill
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= fill_data[i*DW +: DW];
    end
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < WORDS; g++) begin : g_blk
    assign blk_data[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/upd_snoop_resp.sv
`timescale 1ns/1ps
module upd_snoop_resp
  import upd_pkg::*;
#(
  parameter int TAGW = 8
) (
  input  line_st_e        st,
  input  logic [TAGW-1:0] tag,
  input  logic            snp_valid,
  input  logic [1:0]      snp_cmd,
  input  logic [TAGW-1:0] snp_tag,
  output logic            hit,
  output logic            shared_o,
  output logic            flush_o,
  output logic            apply_word,
  output line_st_e        st_nxt
);
  always_comb begin
    hit        = snp_valid && (st != LS_NP) && (tag == snp_tag);
    shared_o   = hit && ((snp_cmd == BC_READ) || (snp_cmd == BC_UPD));
    flush_o    = 1'b0;
    apply_word = 1'b0;
    st_nxt     = st;
    if (hit) begin
      case (snp_cmd)
        BC_READ: begin
          case (st)
            LS_MOD: begin flush_o = 1'b1; st_nxt = LS_SHM; end
            LS_SHM: flush_o = 1'b1;
            LS_EXC: st_nxt = LS_SHC;
            default: ;
          endcase
        end
        BC_UPD: begin
          if (st == LS_SHC || st == LS_SHM) begin
            apply_word = 1'b1;
            st_nxt     = LS_SHC;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/upd_line_ctrl.sv
`timescale 1ns/1ps
module upd_line_ctrl
  import upd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int TAGW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [TAGW-1:0]          cpu_tag,
  input  logic [$clog2(WORDS)-1:0] cpu_word,
  input  logic [DW-1:0]            cpu_wdata,
  output logic                     cpu_done,
  output logic [DW-1:0]            cpu_rdata,
  output logic [2:0]               line_state,
  output logic                     bus_req,
  output logic [1:0]               bus_cmd,
  output logic [TAGW-1:0]          bus_tag,
  output logic [$clog2(WORDS)-1:0] bus_word,
  output logic [DW-1:0]            bus_wdata,
  output logic [WORDS*DW-1:0]      bus_blk,
  input  logic                     bus_gnt,
  input  logic                     bus_shared,
  input  logic [WORDS*DW-1:0]      bus_fill,
  input  logic                     snp_valid,
  input  logic [1:0]               snp_cmd,
  input  logic [TAGW-1:0]          snp_tag,
  input  logic [$clog2(WORDS)-1:0] snp_word,
  input  logic [DW-1:0]            snp_data,
  output logic                     snp_shared,
  output logic                     snp_flush,
  output logic [WORDS*DW-1:0]      snp_flush_data
);
  localparam int IW = $clog2(WORDS);

  line_st_e        st;
  ctl_e            ctl;
  logic [TAGW-1:0] tag;
  logic            rq_we;
  logic [TAGW-1:0] rq_tag;
  logic [IW-1:0]   rq_word;
  logic [DW-1:0]   rq_data;

  logic            snp_hit, snp_apply;
  line_st_e        snp_st_nxt;
  logic            owner, own_go, hit_local, accept, silent_wr;
  logic            fill_en, wr_en;
  logic [IW-1:0]   wr_idx;
  logic [DW-1:0]   wr_data, rd_word;
  logic [WORDS*DW-1:0] blk_data;

  upd_snoop_resp #(.TAGW(TAGW)) u_snoop (
    .st        (st),
    .tag       (tag),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_tag),
    .hit       (snp_hit),
    .shared_o  (snp_shared),
    .flush_o   (snp_flush),
    .apply_word(snp_apply),
    .st_nxt    (snp_st_nxt)
  );

  upd_line_store #(.DW(DW), .WORDS(WORDS)) u_store (
    .clk      (clk),
    .fill_en  (fill_en),
    .fill_data(bus_fill),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (cpu_word),
    .rd_data  (rd_word),
    .blk_data (blk_data)
  );

  assign owner     = (st == LS_SHM) || (st == LS_MOD);
  assign hit_local = (st != LS_NP) && (tag == cpu_tag);
  // a snoop that hits the line this cycle is served first; the request waits
  assign accept    = (ctl == CT_IDLE) && cpu_req && !cpu_done && !snp_hit;
  assign silent_wr = accept && hit_local && cpu_we && ((st == LS_EXC) || (st == LS_MOD));

  assign bus_req   = ((ctl == CT_WB) && owner) || (ctl == CT_FILL) || (ctl == CT_UPD);
  assign own_go    = bus_req && bus_gnt;
  assign bus_tag   = (ctl == CT_WB) ? tag : rq_tag;
  assign bus_word  = rq_word;
  assign bus_wdata = rq_data;
  assign bus_blk   = blk_data;
  assign snp_flush_data = blk_data;
  assign line_state = st;

  always_comb begin
    case (ctl)
      CT_WB:   bus_cmd = BC_WB;
      CT_FILL: bus_cmd = BC_READ;
      CT_UPD:  bus_cmd = BC_UPD;
      default: bus_cmd = BC_NONE;
    endcase
  end

  always_comb begin
    fill_en = (ctl == CT_FILL) && own_go;
    wr_en   = 1'b0;
    wr_idx  = rq_word;
    wr_data = rq_data;
    if (silent_wr) begin
      wr_en   = 1'b1;
      wr_idx  = cpu_word;
      wr_data = cpu_wdata;
    end else if (own_go && ((ctl == CT_UPD) ||
                            ((ctl == CT_FILL) && rq_we && !bus_shared))) begin
      wr_en = 1'b1;
    end else if (snp_apply && !own_go) begin
      wr_en   = 1'b1;
      wr_idx  = snp_word;
      wr_data = snp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LS_NP;
      ctl       <= CT_IDLE;
      tag       <= '0;
      rq_we     <= 1'b0;
      rq_tag    <= '0;
      rq_word   <= '0;
      rq_data   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (snp_hit && !own_go) st <= snp_st_nxt;
      case (ctl)
        CT_IDLE: begin
          if (accept) begin
            rq_we   <= cpu_we;
            rq_tag  <= cpu_tag;
            rq_word <= cpu_word;
            rq_data <= cpu_wdata;
            if (hit_local) begin
              if (!cpu_we) begin
                cpu_rdata <= rd_word;
                cpu_done  <= 1'b1;
              end else if (silent_wr) begin
                st       <= LS_MOD;
                cpu_done <= 1'b1;
              end else begin
                ctl <= CT_UPD;
              end
            end else begin
              ctl <= owner ? CT_WB : CT_FILL;
            end
          end
        end
        CT_WB: begin
          if (!owner) begin
            ctl <= CT_FILL;
          end else if (own_go) begin
            st  <= LS_NP;
            ctl <= CT_FILL;
          end
        end
        CT_FILL: begin
          if (own_go) begin
            tag <= rq_tag;
            if (!rq_we) begin
              st        <= bus_shared ? LS_SHC : LS_EXC;
              cpu_rdata <= bus_fill[rq_word*DW +: DW];
              cpu_done  <= 1'b1;
              ctl       <= CT_IDLE;
            end else if (bus_shared) begin
              st  <= LS_SHC;
              ctl <= CT_UPD;
            end else begin
              st       <= LS_MOD;
              cpu_done <= 1'b1;
              ctl      <= CT_IDLE;
            end
          end
        end
        CT_UPD: begin
          if (own_go) begin
            st       <= bus_shared ? LS_SHM : LS_MOD;
            cpu_done <= 1'b1;
            ctl      <= CT_IDLE;
          end
        end
        default: ctl <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upd_line_ctrl_chk.sv
`timescale 1ns/1ps
module upd_line_ctrl_chk #(
  parameter int BW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    line_state,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic          bus_gnt,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_flush,
  input logic          snp_hit,
  input logic [1:0]    ctl_q,
  input logic [BW-1:0] blk_q
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (rst)
    line_state <= 3'd4);

  p_excl_no_update_r4: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd1) |-> !(bus_req && bus_cmd == 2'd2));

  p_update_from_shared_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'd2) |-> (line_state == 3'd2 || line_state == 3'd3));

  p_snoop_update_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == 2'd2 && snp_hit &&
     (line_state == 3'd2 || line_state == 3'd3) && !(bus_req && bus_gnt))
    |=> (line_state == 3'd2));

  p_flush_leaves_owner_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_flush && !(bus_req && bus_gnt)) |=> (line_state == 3'd3));

  p_copy_held_until_grant_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == 2'd3 && !bus_gnt && !(snp_valid && snp_cmd == 2'd2)) |=> $stable(blk_q));

  p_writeback_from_owner_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'd3) |-> (line_state == 3'd3 || line_state == 3'd4));
endmodule

bind upd_line_ctrl upd_line_ctrl_chk #(.BW(WORDS*DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_state(line_state),
  .bus_req   (bus_req),
  .bus_cmd   (bus_cmd),
  .bus_gnt   (bus_gnt),
  .snp_valid (snp_valid),
  .snp_cmd   (snp_cmd),
  .snp_flush (snp_flush),
  .snp_hit   (snp_hit),
  .ctl_q     (ctl),
  .blk_q     (blk_data)
);

// File: tb/upd_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module upd_line_ctrl_tb_top;
  localparam int DW = 32, WORDS = 4, TAGW = 8, BW = DW*WORDS;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [TAGW-1:0] cpu_tag = '0;
  logic [1:0] cpu_word = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic [2:0] line_state;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [TAGW-1:0] bus_tag;
  logic [1:0] bus_word;
  logic [DW-1:0] bus_wdata;
  logic [BW-1:0] bus_blk;
  logic bus_gnt = 0, bus_shared = 0;
  logic [BW-1:0] bus_fill = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [TAGW-1:0] snp_tag = '0;
  logic [1:0] snp_word = '0;
  logic [DW-1:0] snp_data = '0;
  logic snp_shared, snp_flush;
  logic [BW-1:0] snp_flush_data;

  int n_chk = 0, n_fail = 0;
  logic [BW-1:0] exp_blk, last_blk;
  logic [DW-1:0] last_word;
  logic [1:0] last_idx;
  logic s_shared, s_flush, saw_bus;
  logic [BW-1:0] s_fdata;

  always #2 clk = ~clk;

  upd_line_ctrl #(.DW(DW), .WORDS(WORDS), .TAGW(TAGW)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag),
    .cpu_word(cpu_word), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .line_state(line_state), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_tag(bus_tag),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_blk(bus_blk), .bus_gnt(bus_gnt),
    .bus_shared(bus_shared), .bus_fill(bus_fill), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_tag(snp_tag), .snp_word(snp_word), .snp_data(snp_data), .snp_shared(snp_shared),
    .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  function automatic logic [BW-1:0] mk_blk(input logic [DW-1:0] seed);
    logic [BW-1:0] b;
    for (int i = 0; i < WORDS; i++) b[i*DW +: DW] = seed + DW'(i);
    return b;
  endfunction

  task automatic chk(input string rq, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cpu_start(input logic we, input logic [TAGW-1:0] t, input logic [1:0] w,
                           input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_tag = t; cpu_word = w; cpu_wdata = d;
  endtask

  task automatic cpu_wait();
    saw_bus = 0;
    for (int i = 0; i < 50 && !cpu_done; i++) begin
      @(negedge clk);
      if (bus_req) saw_bus = 1;
    end
    chk("done", cpu_done, 1'b1);
    cpu_req = 0;
  endtask

  task automatic bus_grant(input logic [1:0] ecmd, input logic [TAGW-1:0] etag, input logic shd,
                           input logic [BW-1:0] fill, input string rq);
    @(negedge clk);
    for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
    chk({rq, " bus_cmd"}, bus_cmd, ecmd);
    chk({rq, " bus_tag"}, bus_tag, etag);
    last_blk = bus_blk; last_word = bus_wdata; last_idx = bus_word;
    bus_gnt = 1; bus_shared = shd; bus_fill = fill;
    @(negedge clk);
    bus_gnt = 0; bus_shared = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [TAGW-1:0] t, input logic [1:0] w,
                       input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_tag = t; snp_word = w; snp_data = d;
    #1;
    s_shared = snp_shared; s_flush = snp_flush; s_fdata = snp_flush_data;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic rd_word(input logic [TAGW-1:0] t, input logic [1:0] w,
                         input logic [DW-1:0] e, input string rq);
    cpu_start(0, t, w, '0);
    cpu_wait();
    chk({rq, " rdata"}, cpu_rdata, e);
    chk({rq, " read hit used no bus"}, saw_bus, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 line_state", line_state, 3'd0);
    chk("R1 bus_req", bus_req, 1'b0);
    chk("R1 cpu_done", cpu_done, 1'b0);
    chk("R1 snp_shared", snp_shared, 1'b0);
  endtask

  task automatic t_read_miss_and_silent_write();
    exp_blk = mk_blk(32'hA000_0000);
    cpu_start(0, 8'h11, 2'd2, '0);
    bus_grant(2'd1, 8'h11, 0, exp_blk, "R2 read miss");
    cpu_wait();
    chk("R2 rdata", cpu_rdata, 32'hA000_0002);
    chk("R2 exclusive", line_state, 3'd1);
    cpu_start(1, 8'h11, 2'd1, 32'h1111_0001);
    cpu_wait();
    exp_blk[1*DW +: DW] = 32'h1111_0001;
    chk("R4 no bus from exclusive", saw_bus, 1'b0);
    chk("R4 modified", line_state, 3'd4);
    cpu_start(1, 8'h11, 2'd3, 32'h1111_0003);
    cpu_wait();
    exp_blk[3*DW +: DW] = 32'h1111_0003;
    chk("R4 no bus from modified", saw_bus, 1'b0);
    chk("R4 stays modified", line_state, 3'd4);
    rd_word(8'h11, 2'd1, 32'h1111_0001, "R4");
  endtask

  task automatic t_snoop_read_and_owner_replace();
    snoop(2'd1, 8'h22, 2'd0, '0);
    chk("R11 other tag no shared", s_shared, 1'b0);
    chk("R11 other tag no flush", s_flush, 1'b0);
    chk("R11 other tag state", line_state, 3'd4);
    snoop(2'd1, 8'h11, 2'd0, '0);
    chk("R7 shared on read", s_shared, 1'b1);
    chk("R7 flush from modified", s_flush, 1'b1);
    chk("R7 flush data", s_fdata, exp_blk);
    chk("R7 modified to shared-mod", line_state, 3'd3);
    snoop(2'd1, 8'h11, 2'd0, '0);
    chk("R7 flush from shared-mod", s_flush, 1'b1);
    chk("R7 shared-mod stays", line_state, 3'd3);
    cpu_start(0, 8'h33, 2'd0, '0);
    bus_grant(2'd3, 8'h11, 0, '0, "R9 owner writeback");
    chk("R9 writeback block", last_blk, exp_blk);
    exp_blk = mk_blk(32'hB000_0000);
    bus_grant(2'd1, 8'h33, 1, exp_blk, "R9 read after writeback");
    cpu_wait();
    chk("R2 rdata shared fill", cpu_rdata, 32'hB000_0000);
    chk("R2 shared-clean", line_state, 3'd2);
    snoop(2'd1, 8'h33, 2'd0, '0);
    chk("R7 no flush from shared-clean", s_flush, 1'b0);
    chk("R7 shared-clean stays", line_state, 3'd2);
  endtask

  task automatic t_write_hit_shared();
    cpu_start(1, 8'h33, 2'd3, 32'hD0D0_0003);
    bus_grant(2'd2, 8'h33, 1, '0, "R5 update");
    cpu_wait();
    chk("R5 update word", last_word, 32'hD0D0_0003);
    chk("R5 update index", last_idx, 2'd3);
    chk("R5 shared-mod", line_state, 3'd3);
    exp_blk[3*DW +: DW] = 32'hD0D0_0003;
    rd_word(8'h33, 2'd3, 32'hD0D0_0003, "R12 own update");
    cpu_start(1, 8'h33, 2'd0, 32'hD0D0_0000);
    bus_grant(2'd2, 8'h33, 0, '0, "R5 update unshared");
    cpu_wait();
    chk("R5 modified when alone", line_state, 3'd4);
    exp_blk[0*DW +: DW] = 32'hD0D0_0000;
    rd_word(8'h33, 2'd0, 32'hD0D0_0000, "R12 own update");
  endtask

  task automatic t_snoop_update_and_write_miss();
    snoop(2'd1, 8'h33, 2'd0, '0);
    chk("R7 modified to shared-mod", line_state, 3'd3);
    snoop(2'd2, 8'h33, 2'd2, 32'hEEEE_0002);
    chk("R6 shared on update", s_shared, 1'b1);
    chk("R6 shared-clean", line_state, 3'd2);
    exp_blk[2*DW +: DW] = 32'hEEEE_0002;
    rd_word(8'h33, 2'd2, 32'hEEEE_0002, "R12 snooped update");
    snoop(2'd3, 8'h33, 2'd2, 32'h5555_5555);
    chk("R11 writeback snoop no shared", s_shared, 1'b0);
    chk("R11 writeback snoop state", line_state, 3'd2);
    snoop(2'd2, 8'h44, 2'd2, 32'h6666_6666);
    chk("R11 other tag update state", line_state, 3'd2);
    rd_word(8'h33, 2'd2, 32'hEEEE_0002, "R11 data kept");
    exp_blk = mk_blk(32'hC000_0000);
    cpu_start(1, 8'h55, 2'd1, 32'hCAFE_0001);
    bus_grant(2'd1, 8'h55, 0, exp_blk, "R9 clean replace no writeback");
    cpu_wait();
    exp_blk[1*DW +: DW] = 32'hCAFE_0001;
    chk("R3 write miss alone modified", line_state, 3'd4);
    rd_word(8'h55, 2'd1, 32'hCAFE_0001, "R3");
    rd_word(8'h55, 2'd2, 32'hC000_0002, "R3 merged fill");
    cpu_start(1, 8'h66, 2'd2, 32'hBEEF_0002);
    bus_grant(2'd3, 8'h55, 0, '0, "R9 writeback");
    chk("R9 writeback block", last_blk, exp_blk);
    exp_blk = mk_blk(32'hF000_0000);
    bus_grant(2'd1, 8'h66, 1, exp_blk, "R3 read");
    bus_grant(2'd2, 8'h66, 1, '0, "R3 update after shared read");
    cpu_wait();
    chk("R3 update word", last_word, 32'hBEEF_0002);
    chk("R3 shared-mod", line_state, 3'd3);
    exp_blk[2*DW +: DW] = 32'hBEEF_0002;
    rd_word(8'h66, 2'd2, 32'hBEEF_0002, "R12 write miss update");
  endtask

  task automatic t_pending_write();
    cpu_start(1, 8'h66, 2'd1, 32'h7777_0001);
    for (int i = 0; i < 20 && !bus_req; i++) @(negedge clk);
    snoop(2'd1, 8'h66, 2'd0, '0);
    chk("R8 flush shows old block", s_fdata, exp_blk);
    snoop(2'd2, 8'h66, 2'd1, 32'h8888_0001);
    chk("R8 snooped update while pending state", line_state, 3'd2);
    bus_grant(2'd2, 8'h66, 1, '0, "R8 pending update");
    cpu_wait();
    chk("R8 final state", line_state, 3'd3);
    rd_word(8'h66, 2'd1, 32'h7777_0001, "R8 own word last");
  endtask

  task automatic t_same_cycle();
    exp_blk = mk_blk(32'h9000_0000);
    cpu_start(0, 8'h77, 2'd0, '0);
    bus_grant(2'd3, 8'h66, 0, '0, "R9 writeback");
    bus_grant(2'd1, 8'h77, 0, exp_blk, "R2 read");
    cpu_wait();
    chk("R2 exclusive", line_state, 3'd1);
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'd1; snp_tag = 8'h77;
    cpu_req = 1; cpu_we = 1; cpu_tag = 8'h77; cpu_word = 2'd0; cpu_wdata = 32'h1234_5678;
    #1;
    s_shared = snp_shared;
    @(negedge clk);
    snp_valid = 0;
    chk("R10 snoop seen", s_shared, 1'b1);
    bus_grant(2'd2, 8'h77, 1, '0, "R10 write became update");
    cpu_wait();
    chk("R10 final state", line_state, 3'd3);
    rd_word(8'h77, 2'd0, 32'h1234_5678, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 0;
    t_read_miss_and_silent_write();
    t_snoop_read_and_owner_replace();
    t_write_hit_shared();
    t_snoop_update_and_write_miss();
    t_pending_write();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule